// File: doc/BRIEF.md
# Serial Memory Write Front End (Two-Wire Target)

This block is the target side of a two-wire serial bus for a 16K x 8 non-volatile memory, handling only write transfers. It recovers START and STOP conditions from the bus, compares the target select byte against its own 7-bit address, and takes two memory address bytes. It then streams the data bytes into an external page buffer, one write strobe per byte. When the controller ends a transfer with STOP after at least one data byte, the block issues a single commit pulse carrying the page number. It then holds a busy window of a programmable number of system clocks. During that window it refuses to acknowledge its own address, so a controller can poll for completion.

A write-protect input is sampled once per transfer, at the SCL falling edge that ends the acknowledge of the low address byte. If it is high at that moment, the first data byte is refused and the whole transfer is abandoned. The bus is open-drain: the block only ever pulls SDA low, through a separate output-enable.

Top module: `i2c_eeprom_wr_ctrl`

## Requirements
- R1: When not busy, a select byte whose upper 7 bits equal DEV_ADDR (default 7'h50) and whose bit 0 is 0 is acknowledged. A select byte with another address, or with bit 0 set to 1, is not acknowledged, and the transfer is ignored until the next START.
- R2: The first byte after the select byte is the high address byte and the second is the low one. Bits 15:14 of the 16-bit address are ignored, bits 13:6 form the page number (commit_page_o), and bits 5:0 form the byte offset (buf_offs_o).
- R3: The select byte, both address bytes and every accepted data byte are acknowledged by holding SDA low through the ninth SCL pulse. sda_oe changes only while SCL is low.
- R4: Each accepted data byte produces exactly one buf_we_o pulse carrying the byte and its offset. The first offset is the one from the address, and each later byte uses the previous offset plus one, wrapping from 63 to 0 while the page stays fixed.
- R5: A STOP at a byte boundary after at least one accepted data byte produces one commit_o pulse with the page number. busy_o then stays high for exactly TWR_CYCLES clocks, starting the cycle after the pulse.
- R6: While busy_o is high, the block never drives SDA, acknowledges no select byte (read or write), and makes no buffer writes.
- R7: If WP is high at the falling SCL edge ending the low-address acknowledge, the first data byte is not acknowledged, no buffer write occurs, and no commit follows.
- R8: If WP is low at that edge, later changes of WP during the transfer have no effect: the data bytes are acknowledged and committed.
- R9: A STOP that follows only the address bytes, with no data byte, produces no commit and no busy window.
- R10: A STOP inside a data byte, or a repeated START, abandons the transfer without a commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_o | output | 1 | Data value driven when enabled (always 0, open drain) |
| sda_oe | output | 1 | Pull SDA low when 1 |
| wp_i | input | 1 | Write-protect level |
| buf_clr_o | output | 1 | One-cycle pulse: new write sequence, page buffer should forget earlier bytes |
| buf_we_o | output | 1 | One-cycle pulse: store buf_data_o at buf_offs_o |
| buf_offs_o | output | OFFS_BITS | Byte offset inside the page |
| buf_data_o | output | 8 | Data byte to store |
| commit_o | output | 1 | One-cycle pulse: program the buffered page |
| commit_page_o | output | PAGE_BITS | Page number to program |
| busy_o | output | 1 | Internal write window in progress |

## Verification
The bound checker checks several rules on every cycle. The acknowledge enable only moves while SCL is low. It never drives during the busy window and no buffer write happens in that window. Every commit follows a detected STOP with data loaded and is followed by busy. Buffer strobes are single-cycle. The bench scenarios cover the rest. These are the address split into page and offset, the offset wrap at the page end, and the exact length of the busy window. They also cover the moment at which write protect is strobed, and the cases that must not commit: an address-only STOP, an abort inside a byte, and a repeated START.

// File: rtl/i2c_wr_pkg.sv
package i2c_wr_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_AHI,
    PH_ALO,
    PH_DATA
  } phase_e;

  localparam int BYTE_W = 8;

  // select byte addresses this target for a write
  function automatic logic is_write_sel(input logic [7:0] sel_byte,
                                        input logic [6:0] own_addr);
    return (sel_byte[7:1] == own_addr) && (sel_byte[0] == 1'b0);
  endfunction

endpackage

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic scl_s,
  output logic sda_s,
  output logic wp_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int NSIG = 3;
  localparam logic [NSIG-1:0] IDLE_LVL = 3'b011; // {wp, sda, scl}

  logic [NSIG-1:0] stg [SYNC_STAGES];
  logic            scl_p, sda_p;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stg[g] <= IDLE_LVL;
        end else if (g == 0) begin
          stg[g] <= {wp_i, sda_i, scl_i};
        end else begin
          stg[g] <= stg[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign scl_s = stg[SYNC_STAGES-1][0];
  assign sda_s = stg[SYNC_STAGES-1][1];
  assign wp_s  = stg[SYNC_STAGES-1][2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/i2c_twr_timer.sv
module i2c_twr_timer #(
  parameter int TWR_CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic busy
);

  localparam int CW = $clog2(TWR_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(TWR_CYCLES);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (kick) begin
      remain <= LOAD;
    end else if (remain != '0) begin
      remain <= remain - ONE;
    end
  end

  assign busy = (remain != '0);

endmodule

// File: rtl/i2c_wr_fsm.sv
module i2c_wr_fsm
  import i2c_wr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h50,
  parameter int         PAGE_BITS = 8,
  parameter int         OFFS_BITS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sda_s,
  input  logic                 wp_s,
  input  logic                 scl_rise,
  input  logic                 scl_fall,
  input  logic                 start_det,
  input  logic                 stop_det,
  input  logic                 busy_i,
  output logic                 ack_oe,
  output logic                 loaded,
  output logic                 buf_clr,
  output logic                 buf_we,
  output logic [OFFS_BITS-1:0] buf_offs,
  output logic [BYTE_W-1:0]    buf_data,
  output logic                 commit,
  output logic [PAGE_BITS-1:0] commit_page
);

  localparam int MEM_AW = PAGE_BITS + OFFS_BITS;
  localparam int HI_W   = MEM_AW - BYTE_W;
  localparam logic [OFFS_BITS-1:0] OFFS_ONE = OFFS_BITS'(1);

  function automatic logic [PAGE_BITS-1:0] page_of(input logic [HI_W-1:0] hi,
                                                   input logic [BYTE_W-1:0] lo);
    logic [MEM_AW-1:0] w;
    w = {hi, lo};
    return w[MEM_AW-1:OFFS_BITS];
  endfunction

  function automatic logic [OFFS_BITS-1:0] offs_of(input logic [BYTE_W-1:0] lo);
    return lo[OFFS_BITS-1:0];
  endfunction

  phase_e                phase;
  logic [3:0]            bitcnt;
  logic [BYTE_W-1:0]     shreg;
  logic                  ack_slot;
  logic [HI_W-1:0]       hi_q;
  logic [PAGE_BITS-1:0]  page_q;
  logic [OFFS_BITS-1:0]  offs_q;
  logic                  wp_lat;

  // byte-level decision signals
  logic byte_done, stop_commits, first_blocked;
  assign byte_done     = scl_fall && !ack_slot && (bitcnt == 4'd8);
  assign stop_commits  = (phase == PH_DATA) && loaded && !ack_slot && (bitcnt <= 4'd1);
  assign first_blocked = !loaded && wp_lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_IDLE;
      bitcnt      <= '0;
      shreg       <= '0;
      ack_slot    <= 1'b0;
      ack_oe      <= 1'b0;
      hi_q        <= '0;
      page_q      <= '0;
      offs_q      <= '0;
      wp_lat      <= 1'b0;
      loaded      <= 1'b0;
      buf_clr     <= 1'b0;
      buf_we      <= 1'b0;
      buf_offs    <= '0;
      buf_data    <= '0;
      commit      <= 1'b0;
      commit_page <= '0;
    end else begin
      buf_clr <= 1'b0;
      buf_we  <= 1'b0;
      commit  <= 1'b0;
      if (start_det) begin
        phase    <= PH_DEV;
        bitcnt   <= '0;
        ack_slot <= 1'b0;
        loaded   <= 1'b0;
      end else if (stop_det) begin
        if (stop_commits) begin
          commit      <= 1'b1;
          commit_page <= page_q;
        end
        phase  <= PH_IDLE;
        loaded <= 1'b0;
      end else if (phase != PH_IDLE) begin
        if (scl_rise && !ack_slot && (bitcnt < 4'd8)) begin
          shreg  <= {shreg[BYTE_W-2:0], sda_s};
          bitcnt <= bitcnt + 4'd1;
        end
        if (scl_fall && ack_slot) begin
          ack_oe   <= 1'b0;
          ack_slot <= 1'b0;
          bitcnt   <= '0;
          if (phase == PH_DATA && !loaded) wp_lat <= wp_s;
        end
        if (byte_done) begin
          ack_slot <= 1'b1;
          unique case (phase)
            PH_DEV: begin
              if (is_write_sel(shreg, DEV_ADDR) && !busy_i) begin
                ack_oe <= 1'b1;
                phase  <= PH_AHI;
              end else begin
                phase <= PH_IDLE;
              end
            end
            PH_AHI: begin
              hi_q   <= shreg[HI_W-1:0];
              ack_oe <= 1'b1;
              phase  <= PH_ALO;
            end
            PH_ALO: begin
              page_q  <= page_of(hi_q, shreg);
              offs_q  <= offs_of(shreg);
              buf_clr <= 1'b1;
              ack_oe  <= 1'b1;
              phase   <= PH_DATA;
            end
            PH_DATA: begin
              if (first_blocked) begin
                phase <= PH_IDLE;
              end else begin
                ack_oe   <= 1'b1;
                buf_we   <= 1'b1;
                buf_offs <= offs_q;
                buf_data <= shreg;
                offs_q   <= offs_q + OFFS_ONE;
                loaded   <= 1'b1;
              end
            end
            default: phase <= PH_IDLE;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/i2c_eeprom_wr_ctrl.sv
module i2c_eeprom_wr_ctrl #(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         PAGE_BITS   = 8,
  parameter int         OFFS_BITS   = 6,
  parameter int         TWR_CYCLES  = 5000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_o,
  output logic                 sda_oe,
  input  logic                 wp_i,
  output logic                 buf_clr_o,
  output logic                 buf_we_o,
  output logic [OFFS_BITS-1:0] buf_offs_o,
  output logic [7:0]           buf_data_o,
  output logic                 commit_o,
  output logic [PAGE_BITS-1:0] commit_page_o,
  output logic                 busy_o
);

  // named internal events, visible to the bound checker
  logic scl_s, sda_s, wp_s;
  logic scl_rise, scl_fall, start_det, stop_det;
  logic data_loaded;

  i2c_bus_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .wp_i      (wp_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .wp_s      (wp_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_wr_fsm #(
    .DEV_ADDR  (DEV_ADDR),
    .PAGE_BITS (PAGE_BITS),
    .OFFS_BITS (OFFS_BITS)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .sda_s       (sda_s),
    .wp_s        (wp_s),
    .scl_rise    (scl_rise),
    .scl_fall    (scl_fall),
    .start_det   (start_det),
    .stop_det    (stop_det),
    .busy_i      (busy_o),
    .ack_oe      (sda_oe),
    .loaded      (data_loaded),
    .buf_clr     (buf_clr_o),
    .buf_we      (buf_we_o),
    .buf_offs    (buf_offs_o),
    .buf_data    (buf_data_o),
    .commit      (commit_o),
    .commit_page (commit_page_o)
  );

  i2c_twr_timer #(.TWR_CYCLES(TWR_CYCLES)) u_twr (
    .clk   (clk),
    .rst_n (rst_n),
    .kick  (commit_o),
    .busy  (busy_o)
  );

  assign sda_o = 1'b0;

endmodule

// File: rtl/i2c_wr_ctrl_chk.sv
module i2c_wr_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic sda_oe,
  input logic busy,
  input logic commit,
  input logic buf_we,
  input logic stop_det,
  input logic loaded
);

  AST_ACK_EDGE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s); // R3

  AST_BUSY_SDA_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe); // R6

  AST_BUSY_NO_BUF_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !buf_we); // R6

  AST_COMMIT_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(stop_det)); // R5

  AST_COMMIT_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> busy); // R5

  AST_COMMIT_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(loaded)); // R9

  AST_BUF_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |=> !buf_we); // R4

endmodule

bind i2c_eeprom_wr_ctrl i2c_wr_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_s    (scl_s),
  .sda_oe   (sda_oe),
  .busy     (busy_o),
  .commit   (commit_o),
  .buf_we   (buf_we_o),
  .stop_det (stop_det),
  .loaded   (data_loaded)
);

// File: tb/i2c_eeprom_wr_ctrl_tb.sv
module i2c_eeprom_wr_ctrl_tb;

  localparam int TWR = 1000;
  localparam int Q   = 8;
  localparam logic [6:0] DEV = 7'h50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic sda_line;
  logic sda_o, sda_oe, buf_clr_o, buf_we_o, commit_o, busy_o;
  logic [5:0] buf_offs_o;
  logic [7:0] buf_data_o, commit_page_o;

  always #2 clk = ~clk;

  assign sda_line = sda_m & ~(sda_oe & ~sda_o);

  i2c_eeprom_wr_ctrl #(
    .DEV_ADDR(DEV), .PAGE_BITS(8), .OFFS_BITS(6), .TWR_CYCLES(TWR), .SYNC_STAGES(2)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_o(sda_o), .sda_oe(sda_oe), .wp_i(wp),
    .buf_clr_o(buf_clr_o), .buf_we_o(buf_we_o), .buf_offs_o(buf_offs_o),
    .buf_data_o(buf_data_o), .commit_o(commit_o), .commit_page_o(commit_page_o),
    .busy_o(busy_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // port monitors
  int   log_n = 0;
  logic [5:0] log_off [128];
  logic [7:0] log_dat [128];
  int   n_commit = 0;
  logic [7:0] last_page;
  int   busy_cnt = 0, busy_drive = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      if (buf_we_o) begin
        if (log_n < 128) begin
          log_off[log_n] <= buf_offs_o;
          log_dat[log_n] <= buf_data_o;
        end
        log_n <= log_n + 1;
      end
      if (commit_o) begin
        n_commit  <= n_commit + 1;
        last_page <= commit_page_o;
      end
      if (busy_o) busy_cnt <= busy_cnt + 1;
      if (busy_o && sda_oe) busy_drive <= busy_drive + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_log();
    @(negedge clk);
    log_n = 0; n_commit = 0; busy_cnt = 0;
  endtask

  task automatic qw(); repeat (Q) @(negedge clk); endtask

  task automatic b_start(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw(); endtask
  task automatic b_stop();  sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw(); qw(); endtask
  task automatic b_rstart(); sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); b_start(); endtask

  task automatic b_bit(input logic b);
    sda_m = b; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
  endtask

  task automatic b_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) b_bit(b[i]);
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw();
    ack = !sda_line;
    qw(); scl_m = 1'b0; qw();
  endtask

  task automatic wait_idle();
    int lim = 0;
    repeat (4) @(negedge clk);
    while (busy_o && lim < TWR + 100) begin @(negedge clk); lim++; end
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input logic [7:0] ah, input logic [7:0] al, input int i);
    return 8'(ah * 3 + al + i * 29 + 1);
  endfunction

  function automatic int exp_page(input logic [7:0] ah, input logic [7:0] al);
    return ((ah % 64) * 4) + (al / 64);
  endfunction

  // full write: select, two address bytes, n data bytes, STOP
  task automatic write_txn(input logic [7:0] ah, input logic [7:0] al, input int n,
                           output bit a_dev, output bit a_hi, output bit a_lo, output int n_ack);
    bit a;
    n_ack = 0;
    b_start();
    b_byte({DEV, 1'b0}, a_dev);
    b_byte(ah, a_hi);
    b_byte(al, a_lo);
    for (int i = 0; i < n; i++) begin
      b_byte(pat(ah, al, i), a);
      if (a) n_ack++;
    end
    b_stop();
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit a0, a1, a2, a3;
    int na;
    logic [7:0] ah, al;
    int n;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // reset state (R3 R5 R6)
    chk(sda_oe == 1'b0, "R3 reset sda_oe", int'(sda_oe), 0);
    chk(busy_o == 1'b0, "R6 reset busy", int'(busy_o), 0);
    chk(commit_o == 1'b0, "R5 reset commit", int'(commit_o), 0);

    // sweep of addresses, lengths and page-end wrap (R1 R2 R3 R4 R5)
    for (int k = 0; k < 16; k++) begin
      ah = 8'((k * 13) % 256) | ((k % 2 == 1) ? 8'hC0 : 8'h00);
      al = 8'((k * 71) % 256);
      if (k % 4 == 3) al[5:0] = 6'd62;
      n = 2 + (k % 3);
      clear_log();
      write_txn(ah, al, n, a0, a1, a2, na);
      chk(a0, "R1 select acked", int'(a0), 1);
      chk(a1 && a2, "R3 address bytes acked", int'(a1) + int'(a2), 2);
      chk(na == n, "R3 data acked", na, n);
      chk(log_n == n, "R4 buffer write count", log_n, n);
      for (int i = 0; i < n && i < log_n; i++) begin
        chk(int'(log_off[i]) == (al + i) % 64, "R4 offset with wrap", int'(log_off[i]), (al + i) % 64);
        chk(log_dat[i] == pat(ah, al, i), "R4 data byte", int'(log_dat[i]), int'(pat(ah, al, i)));
      end
      chk(n_commit == 1, "R5 one commit", n_commit, 1);
      chk(int'(last_page) == exp_page(ah, al), "R2 page number", int'(last_page), exp_page(ah, al));
      wait_idle();
      chk(busy_cnt == TWR, "R5 busy length", busy_cnt, TWR);
    end

    // polling during busy (R6)
    clear_log();
    write_txn(8'h01, 8'h05, 1, a0, a1, a2, na);
    @(negedge clk);
    log_n = 0;
    b_start();
    b_byte({DEV, 1'b0}, a0);
    chk(!a0, "R6 write select nacked while busy", int'(a0), 0);
    b_rstart();
    b_byte({DEV, 1'b1}, a1);
    chk(!a1, "R6 read select nacked while busy", int'(a1), 0);
    b_stop();
    chk(busy_o == 1'b1, "R6 still busy during polls", int'(busy_o), 1);
    wait_idle();
    chk(log_n == 0, "R6 no buffer write while busy", log_n, 0);
    chk(busy_drive == 0, "R6 sda free while busy", busy_drive, 0);
    chk(n_commit == 1, "R6 no extra commit", n_commit, 1);

    // wrong address and read bit when idle (R1)
    clear_log();
    b_start();
    b_byte({DEV ^ 7'h01, 1'b0}, a0);
    chk(!a0, "R1 other address nacked", int'(a0), 0);
    b_byte(8'h00, a1);
    chk(!a1, "R1 ignored after nack", int'(a1), 0);
    b_rstart();
    b_byte({DEV, 1'b1}, a2);
    chk(!a2, "R1 read bit nacked", int'(a2), 0);
    b_stop();
    repeat (10) @(negedge clk);
    chk(n_commit == 0 && busy_o == 1'b0, "R1 nothing started", n_commit, 0);

    // write protect high at strobe (R7)
    clear_log();
    wp = 1'b1;
    write_txn(8'h12, 8'h40, 2, a0, a1, a2, na);
    wp = 1'b0;
    chk(a0 && a1 && a2, "R7 header acked", int'(a0) + int'(a1) + int'(a2), 3);
    chk(na == 0, "R7 data nacked", na, 0);
    repeat (10) @(negedge clk);
    chk(log_n == 0, "R7 no buffer write", log_n, 0);
    chk(n_commit == 0 && busy_cnt == 0, "R7 no commit", n_commit, 0);

    // write protect raised after strobe (R8)
    clear_log();
    b_start();
    b_byte({DEV, 1'b0}, a0);
    b_byte(8'h07, a1);
    b_byte(8'h81, a2);
    wp = 1'b1;
    b_byte(8'h5A, a3);
    chk(a3, "R8 first data acked", int'(a3), 1);
    b_byte(8'hA5, a3);
    chk(a3, "R8 second data acked", int'(a3), 1);
    b_stop();
    wp = 1'b0;
    chk(n_commit == 1, "R8 committed", n_commit, 1);
    chk(int'(last_page) == exp_page(8'h07, 8'h81), "R8 page", int'(last_page), exp_page(8'h07, 8'h81));
    wait_idle();

    // address only (R9)
    clear_log();
    write_txn(8'h03, 8'h10, 0, a0, a1, a2, na);
    repeat (10) @(negedge clk);
    chk(a0 && a1 && a2, "R9 header acked", int'(a0) + int'(a1) + int'(a2), 3);
    chk(n_commit == 0 && busy_o == 1'b0, "R9 no commit", n_commit, 0);

    // STOP inside a data byte (R10)
    clear_log();
    b_start();
    b_byte({DEV, 1'b0}, a0);
    b_byte(8'h04, a1);
    b_byte(8'h20, a2);
    b_byte(8'h33, a3);
    for (int i = 0; i < 4; i++) b_bit(1'b1);
    b_stop();
    repeat (10) @(negedge clk);
    chk(log_n == 1, "R10 byte loaded before abort", log_n, 1);
    chk(n_commit == 0 && busy_o == 1'b0, "R10 mid-byte stop no commit", n_commit, 0);

    // repeated START after data (R10)
    clear_log();
    b_start();
    b_byte({DEV, 1'b0}, a0);
    b_byte(8'h05, a1);
    b_byte(8'h00, a2);
    b_byte(8'h44, a3);
    b_rstart();
    b_byte({DEV, 1'b0}, a0);
    chk(a0, "R10 select after repeated start acked", int'(a0), 1);
    b_stop();
    repeat (10) @(negedge clk);
    chk(n_commit == 0 && busy_o == 1'b0, "R10 repeated start no commit", n_commit, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule